// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of maskable peripheral interrupt lines and a small group of trap inputs that can never be masked. It reduces them to a single request towards the CPU. With that request it presents three things: the number of the winning vector, the program-memory address of that vector's entry, and the priority of the winner. The CPU answers with a one-cycle acknowledge pulse.

Each maskable source has an enable bit, a sticky pending flag and a 3-bit user priority, all set through a small register-style configuration port. Traps always win over maskable sources. Among maskable sources the highest user priority wins, and within one level the lower vector number wins. A maskable source is only forwarded when its priority is above the CPU's current level. One control bit moves every vector fetch from the primary table to an alternate table. The alternate table lies directly after the primary table and has the same layout.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset `req_o` is low, and every enable, priority, pending flag and the table-select bit read back as zero.
- R2: A high level on `irq_i[s]` at a clock edge sets the pending flag of source s. The flag stays set until that source is acknowledged. It reads back as bit 4 of `cfg_rdata_o` at `cfg_addr_i = s`.
- R3: A maskable source takes part in arbitration only when all of these hold:
  - it is pending;
  - it is enabled (bit 0 of its configuration word);
  - its priority (bits 3:1) is strictly greater than `cpu_ipl_i`.
  A priority of 0 therefore never requests.
- R4: Among eligible maskable sources the highest priority wins. On equal priority the source with the lower index (lower vector) wins.
- R5: A pending trap wins over every maskable source, whatever the enables and `cpu_ipl_i`. Among traps the lower trap number wins, and a trap reports priority 7.
- R6: Trap t uses vector t. Maskable source s uses vector N_TRAP + s, which is 8 + s by default.
- R7: The entry address is 0x000004 + 2 × vector when bit 0 of the control word (`cfg_addr_i = N_SRC`) is 0. When that bit is 1, 252 is added, which selects the alternate table of 126 entries.
- R8: The request and vector appear exactly two clock edges after the input that raises them, however many requests are pending. The result then stays stable while `req_o` is high and `ack_i` is low.
- R9: When `ack_i` is high while `req_o` is high:
  - the pending flag of the presented vector is cleared;
  - `req_o` drops for one cycle;
  - the next winner is presented on the following edge.
  The priority of the acknowledged vector is on `prio_o` during the acknowledge.
- R10: A pending flag whose source is disabled stays set. It joins arbitration again once the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Maskable interrupt request lines |
| trap_i | input | N_TRAP | Trap request lines, never masked |
| cpu_ipl_i | input | 3 | Current CPU priority level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration address: source index, or N_SRC for the control word |
| cfg_wdata_i | input | 8 | Write data: bit 0 enable, bits 3:1 priority; control word bit 0 selects the alternate table |
| cfg_rdata_o | output | 8 | Read data: bit 0 enable, bits 3:1 priority, bit 4 pending |
| ack_i | input | 1 | CPU acknowledge pulse |
| req_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 7 | Winning vector number |
| addr_o | output | 24 | Program address of the vector entry |
| prio_o | output | 3 | Priority of the presented vector |

## Verification
On every cycle the assertions check the following:
- the presented result holds still until it is acknowledged;
- an acknowledge drops the request and clears at most one flag;
- pending flags neither vanish without an acknowledge nor fail to set;
- a vector loaded while a trap was pending is a trap vector;
- a loaded maskable vector's priority exceeds the CPU level at load time;
- addresses stay inside the two tables.

Only the bench scenarios can show that the right winner is chosen among mixed priorities, ties and disabled sources. The same holds for the exact addresses in both tables, the two-edge latency, and the rejoining of a flag after its source is re-enabled.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int VEC_SLOTS = 126;
  localparam logic [23:0] TBL_BASE = 24'h000004;
  localparam logic [23:0] ALT_OFFS = 24'(2 * VEC_SLOTS);

  typedef logic [2:0] prio_t;

  typedef struct packed {
    logic       req;
    logic [6:0] vec;
    prio_t      prio;
  } win_t;
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs #(
  parameter int N_SRC  = 16,
  parameter int N_TRAP = 8,
  parameter int AW     = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      irq_i,
  input  logic [N_TRAP-1:0]     trap_i,
  input  logic                  cfg_we_i,
  input  logic [AW-1:0]         cfg_addr_i,
  input  logic [7:0]            cfg_wdata_i,
  output logic [7:0]            cfg_rdata_o,
  input  logic [N_SRC-1:0]      clr_src_i,
  input  logic [N_TRAP-1:0]     clr_trap_i,
  output logic [N_SRC-1:0]      src_pend_o,
  output logic [N_SRC-1:0]      src_en_o,
  output logic [N_SRC-1:0][2:0] src_prio_o,
  output logic [N_TRAP-1:0]     trap_pend_o,
  output logic                  alt_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic sel;
    assign sel = cfg_we_i && (cfg_addr_i == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_pend_o[i] <= 1'b0;
        src_en_o[i]   <= 1'b0;
        src_prio_o[i] <= '0;
      end else begin
        src_pend_o[i] <= (src_pend_o[i] & ~clr_src_i[i]) | irq_i[i];
        if (sel) begin
          src_en_o[i]   <= cfg_wdata_i[0];
          src_prio_o[i] <= cfg_wdata_i[3:1];
        end
      end
    end

    assert_pend_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[i] |=> src_pend_o[i]);
    assert_pend_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_pend_o[i] && !clr_src_i[i] |=> src_pend_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_pend_o <= '0;
      alt_o       <= 1'b0;
    end else begin
      trap_pend_o <= (trap_pend_o & ~clr_trap_i) | trap_i;
      if (cfg_we_i && cfg_addr_i == AW'(N_SRC)) alt_o <= cfg_wdata_i[0];
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (cfg_addr_i == AW'(i))
        cfg_rdata_o = {3'b000, src_pend_o[i], src_prio_o[i], src_en_o[i]};
    if (cfg_addr_i == AW'(N_SRC)) cfg_rdata_o = {7'b0, alt_o};
  end

  assert_clr_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_src_i, clr_trap_i}));
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_TRAP = 8
) (
  input  logic [N_SRC-1:0]      src_pend_i,
  input  logic [N_SRC-1:0]      src_en_i,
  input  logic [N_SRC-1:0][2:0] src_prio_i,
  input  logic [N_TRAP-1:0]     trap_pend_i,
  input  prio_t                 cpu_ipl_i,
  output win_t                  win_o
);
  always_comb begin
    win_o = '0;
    // traps: scan high to low so the lowest number is kept
    for (int t = N_TRAP - 1; t >= 0; t--) begin
      if (trap_pend_i[t]) begin
        win_o.req  = 1'b1;
        win_o.vec  = 7'(t);
        win_o.prio = 3'd7;
      end
    end
    if (!win_o.req) begin
      // strict compare keeps the lower index on equal priority
      for (int s = 0; s < N_SRC; s++) begin
        if (src_pend_i[s] && src_en_i[s] && (src_prio_i[s] > cpu_ipl_i) &&
            (src_prio_i[s] > win_o.prio)) begin
          win_o.req  = 1'b1;
          win_o.vec  = 7'(N_TRAP + s);
          win_o.prio = src_prio_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/pvic_vecout.sv
module pvic_vecout
  import pvic_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_TRAP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  win_t              win_i,
  input  logic              alt_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [6:0]        vec_o,
  output logic [23:0]       addr_o,
  output prio_t             prio_o,
  output logic [N_SRC-1:0]  clr_src_o,
  output logic [N_TRAP-1:0] clr_trap_o
);
  logic take;
  assign take = req_o && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      vec_o  <= '0;
      addr_o <= '0;
      prio_o <= '0;
    end else if (take) begin
      req_o <= 1'b0;
    end else if (!req_o) begin
      req_o  <= win_i.req;
      vec_o  <= win_i.vec;
      prio_o <= win_i.prio;
      addr_o <= TBL_BASE + (alt_i ? ALT_OFFS : 24'd0) + {16'd0, win_i.vec, 1'b0};
    end
  end

  for (genvar t = 0; t < N_TRAP; t++) begin : g_ctrap
    assign clr_trap_o[t] = take && (vec_o == 7'(t));
  end
  for (genvar s = 0; s < N_SRC; s++) begin : g_csrc
    assign clr_src_o[s] = take && (vec_o == 7'(N_TRAP + s));
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(vec_o) && $stable(addr_o) && $stable(prio_o));
  assert_ack_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);
  assert_addr_span_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !addr_o[0] && addr_o >= TBL_BASE && addr_o < TBL_BASE + 24'(4 * VEC_SLOTS));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_TRAP = 8,
  localparam int AW    = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [N_TRAP-1:0] trap_i,
  input  logic [2:0]        cpu_ipl_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              ack_i,
  output logic              req_o,
  output logic [6:0]        vec_o,
  output logic [23:0]       addr_o,
  output logic [2:0]        prio_o
);
  logic [N_SRC-1:0]      src_pend, src_en, clr_src;
  logic [N_SRC-1:0][2:0] src_prio;
  logic [N_TRAP-1:0]     trap_pend, clr_trap;
  logic                  alt;
  win_t                  win;

  pvic_regs #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .irq_i, .trap_i,
    .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .clr_src_i(clr_src), .clr_trap_i(clr_trap),
    .src_pend_o(src_pend), .src_en_o(src_en), .src_prio_o(src_prio),
    .trap_pend_o(trap_pend), .alt_o(alt)
  );

  pvic_arb #(.N_SRC(N_SRC), .N_TRAP(N_TRAP)) u_arb (
    .src_pend_i(src_pend), .src_en_i(src_en), .src_prio_i(src_prio),
    .trap_pend_i(trap_pend), .cpu_ipl_i(cpu_ipl_i), .win_o(win)
  );

  pvic_vecout #(.N_SRC(N_SRC), .N_TRAP(N_TRAP)) u_out (
    .clk_i, .rst_ni, .win_i(win), .alt_i(alt), .ack_i,
    .req_o, .vec_o, .addr_o, .prio_o,
    .clr_src_o(clr_src), .clr_trap_o(clr_trap)
  );

  assert_trap_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && $past(|trap_pend) |-> vec_o < 7'(N_TRAP));
  assert_above_ipl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && vec_o >= 7'(N_TRAP) |-> prio_o > $past(cpu_ipl_i));
  assert_vec_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> vec_o < 7'(N_TRAP + N_SRC));
endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 16;
  localparam int N_TRAP = 8;
  localparam int AW = $clog2(N_SRC + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_SRC-1:0] irq = '0;
  logic [N_TRAP-1:0] trap = '0;
  logic [2:0] ipl = '0;
  logic we = 1'b0, ack = 1'b0;
  logic [AW-1:0] caddr = '0;
  logic [7:0] wdata = '0, rdata;
  logic req;
  logic [6:0] vec;
  logic [23:0] addr;
  logic [2:0] prio;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_vec_intc #(.N_SRC(N_SRC), .N_TRAP(N_TRAP)) u_prio_vec_intc (
    .clk_i(clk), .rst_ni, .irq_i(irq), .trap_i(trap), .cpu_ipl_i(ipl),
    .cfg_we_i(we), .cfg_addr_i(caddr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .ack_i(ack), .req_o(req), .vec_o(vec), .addr_o(addr), .prio_o(prio)
  );

  typedef struct packed {
    logic [15:0] irq;
    logic [7:0]  trap;
    logic [2:0]  ipl;
    logic        alt;
    logic        exp_req;
    logic [6:0]  exp_vec;
    logic [2:0]  exp_prio;
  } row_t;

  // source s priority = (3*s) mod 8, source 5 disabled
  localparam row_t TBL [10] = '{
    '{16'h0001, 8'h00, 3'd0, 1'b0, 1'b0, 7'd0,  3'd0},
    '{16'h0006, 8'h00, 3'd0, 1'b0, 1'b1, 7'd10, 3'd6},
    '{16'h0404, 8'h00, 3'd0, 1'b0, 1'b1, 7'd10, 3'd6},
    '{16'h2020, 8'h00, 3'd0, 1'b0, 1'b1, 7'd21, 3'd7},
    '{16'h0006, 8'h00, 3'd6, 1'b0, 1'b0, 7'd0,  3'd0},
    '{16'h0006, 8'h00, 3'd5, 1'b0, 1'b1, 7'd10, 3'd6},
    '{16'h2000, 8'h0C, 3'd7, 1'b0, 1'b1, 7'd2,  3'd7},
    '{16'h0082, 8'h00, 3'd0, 1'b1, 1'b1, 7'd15, 3'd5},
    '{16'h0000, 8'h80, 3'd0, 1'b0, 1'b1, 7'd7,  3'd7},
    '{16'h8000, 8'h00, 3'd4, 1'b0, 1'b1, 7'd23, 3'd5}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    irq = '0; trap = '0; ack = 1'b0; we = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic wr(int a, logic [7:0] d);
    we = 1'b1; caddr = AW'(a); wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic setup(logic alt);
    for (int s = 0; s < N_SRC; s++)
      wr(s, {4'b0, 3'((3 * s) % 8), (s != 5)});
    wr(N_SRC, {7'b0, alt});
  endtask

  task automatic pulse(logic [15:0] i, logic [7:0] t);
    irq = i; trap = t;
    tick();
    irq = '0; trap = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 req in reset", 32'(req), 0);
    rst_ni = 1'b1;
    tick();
    caddr = AW'(3);
    #1 chk("R1 src cfg readback", 32'(rdata), 0);
    caddr = AW'(N_SRC);
    #1 chk("R1 alt readback", 32'(rdata), 0);

    // table walk: R3/R4/R5/R6/R7
    for (int k = 0; k < 10; k++) begin
      do_reset();
      setup(TBL[k].alt);
      ipl = TBL[k].ipl;
      pulse(TBL[k].irq, TBL[k].trap);
      tick();
      chk($sformatf("R3/R4/R5 row %0d req", k), 32'(req), 32'(TBL[k].exp_req));
      if (TBL[k].exp_req) begin
        chk($sformatf("R4/R5/R6 row %0d vec", k), 32'(vec), 32'(TBL[k].exp_vec));
        chk($sformatf("R7 row %0d addr", k), 32'(addr),
            32'(4 + 2 * TBL[k].exp_vec + (TBL[k].alt ? 252 : 0)));
        chk($sformatf("R5/R9 row %0d prio", k), 32'(prio), 32'(TBL[k].exp_prio));
      end
    end

    // R8 latency, R2 pending readback
    do_reset();
    setup(1'b0);
    ipl = 3'd0;
    pulse(16'h0004, 8'h00);
    chk("R8 no req after one edge", 32'(req), 0);
    caddr = AW'(2);
    #1 chk("R2 pending set", 32'(rdata[4]), 1);
    tick();
    chk("R8 req after two edges", 32'(req), 1);
    chk("R8 vec after two edges", 32'(vec), 10);

    // R8 hold while unacknowledged
    pulse(16'h2000, 8'h00);
    tick(); tick();
    chk("R8 held req", 32'(req), 1);
    chk("R8 held vec", 32'(vec), 10);
    chk("R9 prio reported", 32'(prio), 6);

    // R9 acknowledge
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R9 req drops", 32'(req), 0);
    caddr = AW'(2);
    #1 chk("R9 winner flag cleared", 32'(rdata[4]), 0);
    caddr = AW'(13);
    #1 chk("R2 other flag kept", 32'(rdata[4]), 1);
    tick();
    chk("R9 next req", 32'(req), 1);
    chk("R9 next vec", 32'(vec), 21);

    // R9 trap acknowledge clears trap
    do_reset();
    setup(1'b0);
    pulse(16'h0000, 8'h08);
    tick();
    chk("R5 trap req", 32'(vec), 3);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    tick();
    chk("R9 trap cleared", 32'(req), 0);

    // R10 disabled flag survives and rejoins
    do_reset();
    setup(1'b0);
    wr(7, 8'h0A);
    pulse(16'h0080, 8'h00);
    tick(); tick();
    chk("R10 disabled no req", 32'(req), 0);
    caddr = AW'(7);
    #1 chk("R10 flag kept", 32'(rdata[4]), 1);
    wr(7, 8'h0B);
    tick();
    chk("R10 rejoin req", 32'(req), 1);
    chk("R10 rejoin vec", 32'(vec), 15);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule